// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches 32 synchronised GPIO input levels and turns them into one interrupt request line. Software configures each pin on its own. A pin can be level-sensitive or edge-sensitive, and a polarity bit chooses which level or edge is active. A separate per-pin bit makes the pin react to both rising and falling transitions, so software never has to flip the polarity after each event. An edge event is held in a sticky flag until software clears it. A level source has no memory and tracks the pin directly.

Every configuration register is 32 pins wide and is reached as two 16-bit halves. The half at the base offset covers pins 0 to 15, and the half at base+4 covers pins 16 to 31. A write carries a per-bit write enable in bits 31:16 and the new values in bits 15:0, so a pin is updated without a read-modify-write. Reads return the selected half in bits 15:0 and zero in bits 31:16. The register port is a plain single-cycle write strobe with a combinational read, and it has no flow control.

The block reports two views of each pin. The unfiltered view shows whether the pin has a pending event. The reportable view is that event gated by the pin's enable bit and its mask bit. The interrupt output is the OR of the reportable view.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1 and the enable, type, polarity and both-edge registers read 0. Reads of 0x18 and 0x1C return 0x0000FFFF and irq_o is 0.
- R2: A write to a register half changes only those bits whose write enable (wdata bit i+16) is 1, setting them to wdata bit i. Offset base+0 maps to pins 0..15, base+4 to pins 16..31. Register bases: enable 0x10, mask 0x18, type 0x20, polarity 0x28, both-edge 0x30.
- R3: With type bit 0 and both-edge bit 0 (level mode), the pin's raw status (0x58/0x5C) is 1 while the pin equals its polarity bit (1 = active high, 0 = active low), and is 0 otherwise.
- R4: With type bit 1 and both-edge bit 0, polarity 1 latches raw status on a 0-to-1 transition and polarity 0 latches it on a 1-to-0 transition. The opposite transition does not latch.
- R5: A both-edge bit of 1 latches raw status on either transition, whatever the type and polarity bits hold.
- R6: An edge is latched only if the pin's enable bit was 1 on the clock edge where the transition is seen.
- R7: A write to 0x60/0x64 with both the write-enable bit and the data bit set clears that pin's latched edge. Data bits without a write enable leave the latch alone. If a qualifying edge arrives in the same cycle as the clear, the latch stays 1.
- R8: A mask bit of 1 forces the pin's status (0x50/0x54) to 0 and keeps it out of irq_o, while raw status still shows the event.
- R9: Status equals raw AND enable AND NOT mask for each pin, and irq_o is 1 exactly when any status bit is 1.
- R10: Writes to the status and raw-status offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Synchronised pin levels |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register half |
| reg_wdata | input | 32 | Write enables in 31:16, values in 15:0 |
| reg_rdata | output | 32 | Combinational read of the addressed half |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two things can land on the same flag in one cycle: a qualifying edge that sets it and the end-of-interrupt write that clears it. The bench first latches an edge on one pin and drops the pin back. It then raises the pin on the same falling clock edge that it drives the clear write, so both take effect at the next rising edge. It expects the raw-status bit still to read 1, and a lone clear afterwards to bring it to 0. Masking and disabling are then applied on top of a held event to show that the raw view keeps it while the reportable view and the output drop it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPINS  = 32;
  localparam int HALF_W = 16;
  localparam int NHALF  = NPINS / HALF_W;
  localparam int AW     = 8;
  localparam int DW     = 2 * HALF_W;

  localparam logic [AW-1:0] A_EN   = 8'h10;
  localparam logic [AW-1:0] A_MASK = 8'h18;
  localparam logic [AW-1:0] A_TYPE = 8'h20;
  localparam logic [AW-1:0] A_POL  = 8'h28;
  localparam logic [AW-1:0] A_BOTH = 8'h30;
  localparam logic [AW-1:0] A_STAT = 8'h50;
  localparam logic [AW-1:0] A_RAW  = 8'h58;
  localparam logic [AW-1:0] A_EOI  = 8'h60;

  typedef struct packed {
    logic [NPINS-1:0] en;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] typ;
    logic [NPINS-1:0] pol;
    logic [NPINS-1:0] both;
  } irq_cfg_t;

  // Upper half of the write word enables, lower half supplies the value.
  function automatic logic [HALF_W-1:0] wm_merge(input logic [HALF_W-1:0] old,
                                                 input logic [DW-1:0]     wd);
    return (old & ~wd[DW-1:HALF_W]) | (wd[HALF_W-1:0] & wd[DW-1:HALF_W]);
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] stat_i,
  output logic [DW-1:0]    rdata,
  output irq_cfg_t         cfg_o,
  output logic [NPINS-1:0] eoi_o
);
  logic [AW-1:0]    base;
  logic             aligned;
  logic [NPINS-1:0] en_v, mask_v, typ_v, pol_v, both_v;

  assign base    = {addr[AW-1:3], 3'b000};
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic              sel;
    logic [HALF_W-1:0] en_h, mask_h, typ_h, pol_h, both_h;

    assign sel = wr && aligned && (addr[2] == 1'(h));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_h   <= '0;
        mask_h <= '1;
        typ_h  <= '0;
        pol_h  <= '0;
        both_h <= '0;
      end else if (sel) begin
        case (base)
          A_EN:    en_h   <= wm_merge(en_h, wdata);
          A_MASK:  mask_h <= wm_merge(mask_h, wdata);
          A_TYPE:  typ_h  <= wm_merge(typ_h, wdata);
          A_POL:   pol_h  <= wm_merge(pol_h, wdata);
          A_BOTH:  both_h <= wm_merge(both_h, wdata);
          default: ;
        endcase
      end
    end

    assign en_v  [h*HALF_W +: HALF_W] = en_h;
    assign mask_v[h*HALF_W +: HALF_W] = mask_h;
    assign typ_v [h*HALF_W +: HALF_W] = typ_h;
    assign pol_v [h*HALF_W +: HALF_W] = pol_h;
    assign both_v[h*HALF_W +: HALF_W] = both_h;
    assign eoi_o [h*HALF_W +: HALF_W] = (sel && base == A_EOI) ?
                                        (wdata[HALF_W-1:0] & wdata[DW-1:HALF_W]) : '0;
  end

  assign cfg_o = '{en: en_v, mask: mask_v, typ: typ_v, pol: pol_v, both: both_v};

  always_comb begin
    logic [NPINS-1:0] src;
    case (base)
      A_EN:    src = en_v;
      A_MASK:  src = mask_v;
      A_TYPE:  src = typ_v;
      A_POL:   src = pol_v;
      A_BOTH:  src = both_v;
      A_STAT:  src = stat_i;
      A_RAW:   src = raw_i;
      default: src = '0;
    endcase
    if (!aligned) src = '0;
    rdata = {{HALF_W{1'b0}}, src[addr[2]*HALF_W +: HALF_W]};
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  input  logic typ_i,
  input  logic pol_i,
  input  logic both_i,
  input  logic eoi_i,
  output logic set_o,
  output logic latch_o,
  output logic raw_o
);
  logic prev_q, latch_q;
  logic rise, fall, qual, edge_mode;

  assign rise      = pin_i & ~prev_q;
  assign fall      = ~pin_i & prev_q;
  assign edge_mode = typ_i | both_i;
  assign qual      = both_i ? (rise | fall) : (pol_i ? rise : fall);
  assign set_o     = en_i & edge_mode & qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (set_o)      latch_q <= 1'b1;
      else if (eoi_i) latch_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign raw_o   = edge_mode ? latch_q : ~(pin_i ^ pol_i);
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int PINS = 32
) (
  input  logic [PINS-1:0] raw_i,
  input  logic [PINS-1:0] en_i,
  input  logic [PINS-1:0] mask_i,
  output logic [PINS-1:0] stat_o,
  output logic            irq_o
);
  assign stat_o = raw_i & en_i & ~mask_i;
  assign irq_o  = |stat_o;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_o
);
  irq_cfg_t         cfg;
  logic [NPINS-1:0] eoi, set_v, latch_v, raw_v, stat_v;

  gpio_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .raw_i(raw_v), .stat_i(stat_v), .rdata(reg_rdata), .cfg_o(cfg), .eoi_o(eoi)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[i]),
      .en_i(cfg.en[i]), .typ_i(cfg.typ[i]), .pol_i(cfg.pol[i]),
      .both_i(cfg.both[i]), .eoi_i(eoi[i]),
      .set_o(set_v[i]), .latch_o(latch_v[i]), .raw_o(raw_v[i])
    );
  end

  gpio_irq_merge #(.PINS(NPINS)) u_merge (
    .raw_i(raw_v), .en_i(cfg.en), .mask_i(cfg.mask), .stat_o(stat_v), .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin,
  input irq_cfg_t         cfg,
  input logic [NPINS-1:0] eoi,
  input logic [NPINS-1:0] set_v,
  input logic [NPINS-1:0] latch_v,
  input logic [NPINS-1:0] raw_v,
  input logic [NPINS-1:0] stat_v,
  input logic             irq
);
  a_r1_mask_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg.mask == '1));

  a_r3_level_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_v ^ ~(pin ^ cfg.pol)) & ~cfg.typ & ~cfg.both) == '0);

  a_r6_no_latch_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (latch_v & ~$past(latch_v) & ~$past(cfg.en)) == '0);

  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    |(eoi & ~set_v) |=> (latch_v & $past(eoi & ~set_v)) == '0);

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |set_v |=> (latch_v & $past(set_v)) == $past(set_v));

  a_r8_mask_blocks_status: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_v & cfg.mask) == '0);

  a_r9_irq_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(raw_v & cfg.en & ~cfg.mask));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin(pin_i), .cfg(cfg), .eoi(eoi),
  .set_v(set_v), .latch_v(latch_v), .raw_v(raw_v), .stat_v(stat_v), .irq(irq_o)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = 32'hFFFF_FFFF;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int          nchk = 0;
  int          nerr = 0;
  logic [31:0] d, d2;

  // {type, pol, both, start level, end level, expected raw}
  localparam logic [5:0] VEC [9] = '{
    6'b010011, 6'b000101, 6'b010100, 6'b110011, 6'b110100,
    6'b100101, 6'b101011, 6'b111101, 6'b100010
  };

  always #5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic setbit(input logic [7:0] base, input int p, input logic v);
    wr(base + ((p >= 16) ? 8'd4 : 8'd0), (32'h1 << (16 + p % 16)) | (32'(v) << (p % 16)));
  endtask

  task automatic rawbit(input int p, output logic b);
    logic [31:0] t;
    rd(8'h58 + ((p >= 16) ? 8'd4 : 8'd0), t);
    b = t[p % 16];
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h18, d); check(d, 32'h0000_FFFF, "R1 mask lo");
    rd(8'h1C, d); check(d, 32'h0000_FFFF, "R1 mask hi");
    rd(8'h10, d); check(d, 32'h0, "R1 enable");
    rd(8'h30, d); check(d, 32'h0, "R1 both-edge");
    check({31'h0, irq_o}, 32'h0, "R1 irq");

    // R2 write-masked halves
    wr(8'h10, 32'h000F_0005); rd(8'h10, d); check(d, 32'h0000_0005, "R2 partial write");
    wr(8'h10, 32'h0002_FFFF); rd(8'h10, d); check(d, 32'h0000_0007, "R2 only enabled bit");
    wr(8'h14, 32'h8000_8000); rd(8'h14, d); check(d, 32'h0000_8000, "R2 upper half");
    rd(8'h10, d); check(d, 32'h0000_0007, "R2 lower half untouched");
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);

    // R10 read-only offsets
    rd(8'h58, d);
    wr(8'h58, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h58, d2); check(d2, d, "R10 raw unchanged");
    rd(8'h18, d); check(d, 32'h0000_FFFF, "R10 mask unchanged");

    // Table-driven mode checks (R3/R4/R5)
    for (int i = 0; i < 9; i++) begin
      int p;
      p = (i % 2 == 1) ? 21 : 5;
      setbit(8'h20, p, VEC[i][5]);
      setbit(8'h28, p, VEC[i][4]);
      setbit(8'h30, p, VEC[i][3]);
      pins[p] = VEC[i][2];
      repeat (2) @(negedge clk);
      setbit(8'h60, p, 1'b1);
      pins[p] = VEC[i][1];
      repeat (2) @(negedge clk);
      rawbit(p, b);
      check({31'h0, b}, {31'h0, VEC[i][0]},
            VEC[i][3] ? "R5 both-edge vector" : (VEC[i][5] ? "R4 edge vector" : "R3 level vector"));
    end

    wr(8'h60, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);

    // R6 enable gating on pin 9, rising edge mode
    pins[9] = 1'b0;
    setbit(8'h20, 9, 1'b1); setbit(8'h28, 9, 1'b1); setbit(8'h10, 9, 1'b0);
    repeat (2) @(negedge clk);
    pins[9] = 1'b1;
    repeat (2) @(negedge clk);
    rawbit(9, b); check({31'h0, b}, 32'h0, "R6 disabled edge ignored");
    setbit(8'h10, 9, 1'b1);
    pins[9] = 1'b0; repeat (2) @(negedge clk);
    pins[9] = 1'b1; repeat (2) @(negedge clk);
    rawbit(9, b); check({31'h0, b}, 32'h1, "R6 enabled edge latched");

    // R8 / R9 masking and gating
    rd(8'h50, d); check(d, 32'h0, "R8 masked status");
    check({31'h0, irq_o}, 32'h0, "R8 masked irq");
    wr(8'h18, 32'h0200_0000);
    rd(8'h50, d); check(d, 32'h0000_0200, "R9 status after unmask");
    check({31'h0, irq_o}, 32'h1, "R9 irq asserted");
    setbit(8'h10, 9, 1'b0);
    rd(8'h50, d); check(d, 32'h0, "R9 status gated by enable");
    check({31'h0, irq_o}, 32'h0, "R9 irq gated by enable");
    rd(8'h58, d); check(d & 32'h200, 32'h200, "R8 raw keeps event");
    setbit(8'h10, 9, 1'b1);

    // R7 end-of-interrupt
    wr(8'h60, 32'h0000_0200);
    rawbit(9, b); check({31'h0, b}, 32'h1, "R7 clear without write enable");
    wr(8'h60, 32'h0200_0200);
    rawbit(9, b); check({31'h0, b}, 32'h0, "R7 clear");
    check({31'h0, irq_o}, 32'h0, "R7 irq after clear");
    pins[9] = 1'b0; repeat (2) @(negedge clk);
    pins[9] = 1'b1; repeat (2) @(negedge clk);
    pins[9] = 1'b0; repeat (2) @(negedge clk);
    @(negedge clk);
    pins[9] = 1'b1;
    reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h0200_0200;
    @(negedge clk);
    reg_wr = 1'b0;
    rawbit(9, b); check({31'h0, b}, 32'h1, "R7 edge wins over clear");
    wr(8'h60, 32'h0200_0200);
    rawbit(9, b); check({31'h0, b}, 32'h0, "R7 later clear");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule